// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps two component predictors and a per-branch chooser. The local component is a table of 2-bit saturating counters indexed by branch address alone. The correlating component is a table of 2-bit counters: the branch address selects a row, and the outcomes of the two most recent resolved branches select one of four counters in that row. The chooser is a third table of 2-bit counters indexed by branch address. It decides which component's guess is used.

On the fetch side the pipeline presents a branch address and, in the same cycle, receives the final guess and both component guesses. The pipeline carries the component guesses with the branch. On the resolve side it returns the address, the real outcome and the two carried component guesses. On the next clock edge the block trains the component tables and the chooser, and shifts the outcome into the global history.

After reset a two-state controller runs a clearing sweep: ST_CLEAR walks an index across every table entry and writes the weakly-not-taken value. The transition SWEEP_DONE, taken when the index reaches its last value, moves the controller to ST_RUN, where it stays until the next reset.

Top module: `tourney_bp`

## Requirements
- R1: While the controller is in ST_CLEAR (from reset until the sweep ends), `ready` is 0 and `pred_taken`, `pred_local` and `pred_corr` are all 0.
- R2: `ready` rises exactly 2^SWEEP_W clock edges after reset is released, with SWEEP_W = 12 by default, and it then stays at 1.
- R3: Every counter is 2 bits wide. An upper bit of 1 means the counter predicts taken. After the sweep every counter holds 01, so a branch that has never been trained is predicted not taken by every component.
- R4: On resolve, the local counter and the correlating counter each step one place toward the actual outcome and saturate at 00 and 11. A counter at 11 therefore still predicts taken after one not-taken outcome, and predicts not taken after the second.
- R5: The local counter is indexed by `fetch_pc[13:2]` (and by `res_pc[13:2]` on update). The two lowest address bits are dropped.
- R6: The correlating counter index is {pc[11:2], ghist}. The history value used is the one in the register during the fetch cycle or the resolve cycle.
- R7: `pred_taken` equals `pred_corr` when the chooser counter at `pc[13:2]` has its upper bit set, and equals `pred_local` otherwise.
- R8: The chooser counter moves only when exactly one of `res_local_pred` and `res_corr_pred` matched `res_taken`. It steps up (saturating) when the correlating guess was the correct one, and down when the local guess was the correct one.
- R9: Each accepted resolve shifts the 2-bit history left and inserts `res_taken` at bit 0. Without a resolve the history holds its value.
- R10: Resolves presented during ST_CLEAR change no table and no history.
- R11: A fetch and a resolve to the same entry in the same cycle return the counter value from before the update. The update is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | 32 | Address of the branch being fetched |
| pred_taken | output | 1 | Final direction guess |
| pred_local | output | 1 | Local component guess |
| pred_corr | output | 1 | Correlating component guess |
| res_valid | input | 1 | A branch is resolving this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| res_local_pred | input | 1 | Local guess that was carried with the branch |
| res_corr_pred | input | 1 | Correlating guess that was carried with the branch |
| ready | output | 1 | Sweep finished; predictions and updates are active |

## Verification
The bound checker checks four things on every cycle: that the outputs stay quiet while the sweep runs, that `ready` never falls, that the history shifts in the resolved outcome and otherwise holds, and that the final guess agrees with both components whenever they agree. Other behaviour depends on table contents, which no cycle-local property can see. This covers counter saturation and hysteresis, the index slicing and aliasing, chooser training only on disagreement, and old-value reads on a same-cycle collision. These behaviours show up only in the bench, which compares every output against a behavioural model of the three tables on each clock, across directed training sequences and a random branch stream.

// File: rtl/tourney_bp_pkg.sv
package tourney_bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_WEAK_NT = 2'b01;

    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_RUN   = 1'b1
    } bp_state_e;

    // one saturating step of a 2-bit counter
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        nxt = cur;
        if (up && cur != 2'b11) nxt = cur + 2'b01;
        else if (!up && cur != 2'b00) nxt = cur - 2'b01;
        return nxt;
    endfunction

endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
    import tourney_bp_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_idx,
    output ctr_t          rd_ctr,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_idx,
    input  logic          upd_up,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx
);
    localparam int DEPTH = 1 << AW;

    ctr_t ctr_q [DEPTH];
    ctr_t upd_cur;

    assign rd_ctr  = ctr_q[rd_idx];
    assign upd_cur = ctr_q[upd_idx];

    always_ff @(posedge clk) begin
        if (clr_en)
            ctr_q[clr_idx] <= CTR_WEAK_NT;
        else if (upd_en)
            ctr_q[upd_idx] <= ctr_step(upd_cur, upd_up);
    end

endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
    parameter int HW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic          bit_in,
    output logic [HW-1:0] hist
);
    logic [HW-1:0] hist_q;

    generate
        if (HW == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n || clr) hist_q <= '0;
                else if (shift_en) hist_q <= bit_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n || clr) hist_q <= '0;
                else if (shift_en) hist_q <= {hist_q[HW-2:0], bit_in};
            end
        end
    endgenerate

    assign hist = hist_q;

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
    import tourney_bp_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int LOC_AW  = 12,
    parameter int SEL_AW  = 12,
    parameter int ROW_AW  = 10,
    parameter int HIST_W  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic            pred_local,
    output logic            pred_corr,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic            res_local_pred,
    input  logic            res_corr_pred,
    output logic            ready
);
    localparam int COR_AW  = ROW_AW + HIST_W;
    localparam int MAX_LS  = (LOC_AW > SEL_AW) ? LOC_AW : SEL_AW;
    localparam int SWEEP_W = (MAX_LS > COR_AW) ? MAX_LS : COR_AW;
    localparam logic [SWEEP_W-1:0] SWEEP_LAST = '1;

    bp_state_e         state_q, state_d;
    logic [SWEEP_W-1:0] sweep_q;
    logic               clr_en;
    logic               run;
    logic [HIST_W-1:0]  ghist;

    // state register and sweep index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            sweep_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_CLEAR) sweep_q <= sweep_q + 1'b1;
        end
    end

    // next state and controller outputs
    always_comb begin
        state_d = state_q;
        clr_en  = 1'b0;
        run     = 1'b0;
        unique case (state_q)
            ST_CLEAR: begin
                clr_en = 1'b1;
                if (sweep_q == SWEEP_LAST) state_d = ST_RUN; // SWEEP_DONE
            end
            ST_RUN: begin
                run = 1'b1;
            end
        endcase
    end

    assign ready = run;

    logic upd;
    assign upd = run && res_valid;

    // index generation
    logic [LOC_AW-1:0] loc_rd, loc_wr;
    logic [SEL_AW-1:0] sel_rd, sel_wr;
    logic [COR_AW-1:0] cor_rd, cor_wr;

    assign loc_rd = fetch_pc[2 +: LOC_AW];
    assign loc_wr = res_pc[2 +: LOC_AW];
    assign sel_rd = fetch_pc[2 +: SEL_AW];
    assign sel_wr = res_pc[2 +: SEL_AW];
    assign cor_rd = {fetch_pc[2 +: ROW_AW], ghist};
    assign cor_wr = {res_pc[2 +: ROW_AW], ghist};

    // chooser training on disagreement only
    logic loc_ok, cor_ok;
    assign loc_ok = (res_local_pred == res_taken);
    assign cor_ok = (res_corr_pred == res_taken);

    ctr_t loc_ctr, sel_ctr, cor_ctr;

    bp_ctr_table #(.AW(LOC_AW)) u_loc (
        .clk(clk), .rd_idx(loc_rd), .rd_ctr(loc_ctr),
        .upd_en(upd), .upd_idx(loc_wr), .upd_up(res_taken),
        .clr_en(clr_en), .clr_idx(sweep_q[LOC_AW-1:0])
    );

    bp_ctr_table #(.AW(COR_AW)) u_cor (
        .clk(clk), .rd_idx(cor_rd), .rd_ctr(cor_ctr),
        .upd_en(upd), .upd_idx(cor_wr), .upd_up(res_taken),
        .clr_en(clr_en), .clr_idx(sweep_q[COR_AW-1:0])
    );

    bp_ctr_table #(.AW(SEL_AW)) u_sel (
        .clk(clk), .rd_idx(sel_rd), .rd_ctr(sel_ctr),
        .upd_en(upd && (loc_ok != cor_ok)), .upd_idx(sel_wr), .upd_up(cor_ok),
        .clr_en(clr_en), .clr_idx(sweep_q[SEL_AW-1:0])
    );

    bp_ghist #(.HW(HIST_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .clr(clr_en),
        .shift_en(upd), .bit_in(res_taken), .hist(ghist)
    );

    assign pred_local = run && loc_ctr[1];
    assign pred_corr  = run && cor_ctr[1];
    assign pred_taken = run && (sel_ctr[1] ? cor_ctr[1] : loc_ctr[1]);

endmodule

// File: rtl/tourney_bp_chk.sv
module tourney_bp_chk #(
    parameter int HIST_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ready,
    input logic              pred_taken,
    input logic              pred_local,
    input logic              pred_corr,
    input logic              res_valid,
    input logic              res_taken,
    input logic [HIST_W-1:0] ghist
);
    AST_QUIET_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> (!pred_taken && !pred_local && !pred_corr)); // R1

    AST_READY_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready); // R2

    AST_AGREE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_local == pred_corr) |-> (pred_taken == pred_local)); // R7

    AST_HIST_SHIFTS_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && res_valid) |=> (ghist[0] == $past(res_taken))); // R9

    AST_HIST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !res_valid) |=> $stable(ghist)); // R9

    AST_HIST_ZERO_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> (ghist == '0)); // R10

endmodule

bind tourney_bp tourney_bp_chk #(.HIST_W(HIST_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .pred_taken(pred_taken), .pred_local(pred_local), .pred_corr(pred_corr),
    .res_valid(res_valid), .res_taken(res_taken), .ghist(ghist)
);

// File: tb/test_tourney_bp.sv
`timescale 1ns/1ps
module test_tourney_bp;
    localparam int SWEEP = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_taken, pred_local, pred_corr;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic        res_local_pred = 1'b0;
    logic        res_corr_pred = 1'b0;
    logic        ready;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk; // 125 MHz

    tourney_bp i_tourney_bp (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_local(pred_local), .pred_corr(pred_corr),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_local_pred(res_local_pred), .res_corr_pred(res_corr_pred),
        .ready(ready)
    );

    // behavioural model: plain integer arrays
    int m_loc [4096];
    int m_sel [4096];
    int m_cor [4096];
    int m_hist;

    function automatic int li(input logic [31:0] pc); return int'(pc[13:2]); endfunction
    function automatic int ci(input logic [31:0] pc); return int'(pc[11:2]) * 4 + m_hist; endfunction

    function automatic int toward(input int v, input bit up);
        if (up) return (v < 3) ? v + 1 : 3;
        return (v > 0) ? v - 1 : 0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4096; i++) begin
            m_loc[i] = 1; m_sel[i] = 1; m_cor[i] = 1;
        end
        m_hist = 0;
    endtask

    // drive one cycle, compare against the model, then advance the model
    task automatic step(input logic [31:0] fpc, input bit rv, input logic [31:0] rpc,
                        input bit rt, input bit rl, input bit rc);
        int el, ec, et;
        @(negedge clk);
        fetch_pc = fpc; res_valid = rv; res_pc = rpc;
        res_taken = rt; res_local_pred = rl; res_corr_pred = rc;
        #1;
        el = m_loc[li(fpc)] / 2;
        ec = m_cor[ci(fpc)] / 2;
        et = (m_sel[li(fpc)] >= 2) ? ec : el;
        check(pred_local == el, "R5 R4 R11 pred_local", int'(pred_local), el);
        check(pred_corr  == ec, "R6 R9 R11 pred_corr", int'(pred_corr), ec);
        check(pred_taken == et, "R7 R8 pred_taken", int'(pred_taken), et);
        if (rv) begin
            int cidx;
            cidx = ci(rpc);
            m_loc[li(rpc)] = toward(m_loc[li(rpc)], rt);
            m_cor[cidx]    = toward(m_cor[cidx], rt);
            if ((rl == rt) != (rc == rt))
                m_sel[li(rpc)] = toward(m_sel[li(rpc)], rc == rt);
            m_hist = ((m_hist * 2) + int'(rt)) % 4;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        int n;
        logic [31:0] pa, pb, pool [8];
        pa = 32'h0000_0100;
        pb = 32'h0000_0200;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // sweep: resolves attempted all the way through must be ignored
        res_valid = 1'b1; res_pc = pa; res_taken = 1'b1; fetch_pc = pa;
        n = 0;
        while (!ready && n < SWEEP + 10) begin
            #1;
            check(!pred_taken && !pred_local && !pred_corr, "R1 quiet outputs",
                  int'(pred_taken), 0);
            @(negedge clk);
            n++;
        end
        check(n == SWEEP, "R2 sweep length", n, SWEEP);
        res_valid = 1'b0;

        // R10 R3: fresh entry after ignored resolves predicts not taken everywhere
        step(pa, 0, 0, 0, 0, 0);
        check(!pred_local && !pred_corr && !pred_taken, "R10 R3 fresh entry", int'(pred_taken), 0);
        // R11: same-cycle resolve and fetch of pa still reads old value
        step(pa, 1, pa, 1, 0, 0);
        check(!pred_local, "R11 old value on collision", int'(pred_local), 0);
        step(pa, 0, 0, 0, 0, 0);
        check(pred_local && pred_taken, "R3 R4 one taken flips weak counter", int'(pred_local), 1);
        // R4 hysteresis from the strong state
        step(pb, 1, pa, 1, 1, 1);
        step(pb, 1, pa, 0, 1, 1);
        step(pa, 0, 0, 0, 0, 0);
        check(pred_local, "R4 strong survives one miss", int'(pred_local), 1);
        step(pb, 1, pa, 0, 1, 1);
        step(pa, 0, 0, 0, 0, 0);
        check(!pred_local, "R4 second miss flips", int'(pred_local), 0);
        // R8 chooser: correlator right twice moves chooser to use correlator
        step(pb, 1, pb, 1, 0, 1);
        step(pb, 1, pb, 1, 0, 1);
        step(pb, 1, pb, 0, 0, 0);   // both agree: no chooser move
        step(pb, 1, pb, 1, 1, 0);   // local right only: step back down
        step(pb, 1, pb, 1, 1, 0);
        // R5 aliasing: address differing above bit 13 shares the local entry
        step(pa | 32'h0001_0000, 0, 0, 0, 0, 0);
        check(pred_local == 1'b0, "R5 alias of pa", int'(pred_local), 0);

        // alternating pattern on one branch with history
        for (int k = 0; k < 64; k++)
            step(pb, 1, pb, k[0], pred_local, pred_corr);

        // random stream over a small pool, aliases included
        pool[0] = pa; pool[1] = pb; pool[2] = 32'h0000_0104; pool[3] = 32'h0000_4100;
        pool[4] = 32'h0000_1100; pool[5] = 32'h0001_0200; pool[6] = 32'h0000_3ffc; pool[7] = 32'h8000_0008;
        for (int k = 0; k < 2000; k++) begin
            logic [31:0] fp, rp;
            fp = pool[$urandom_range(0, 7)];
            rp = pool[$urandom_range(0, 7)];
            step(fp, 1'($urandom_range(0, 1)), rp, 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule